// File: doc/BRIEF.md
# Reference-Counted Line Pinning for a Set-Associative Cache

This block keeps the pinning state of every line in a set-associative last-level cache. Each line holds a small count of the data objects that an upcoming compute tile still has to read from it. While that count is nonzero the line is pinned, and the victim logic must not evict it. A refill engine loads a line's count when it stages a tile. Each object the tile consumes lowers the count by one. A single pulse at the end of the tile releases every line at once.

The block gives the replacement logic a mask of replaceable ways for a queried set. It also enforces a forward-progress rule: a set may never have all of its ways pinned. A request that would pin the last free way of a set is refused, and the requester sees a retry indication in the same cycle. A consume that arrives at a line that is not pinned is a bookkeeping fault. The count stays at zero and a sticky flag is raised.

Top module: `line_lock_tracker`

## Requirements
- R1: After reset every count is zero, `repl_mask` is all ones for every set, and `lock_retry` and `err_underflow` are low.
- R2: An accepted lock request loads `lock_count` into the addressed line's count at the next clock edge. With a nonzero count, that way's bit in `repl_mask` reads 0 from then on.
- R3: A consume at a line with a nonzero count lowers the count by exactly one per event. The way becomes replaceable (mask bit 1) only after as many consumes as the loaded count.
- R4: A `tile_done` pulse zeroes every count at the next edge. A lock or consume in the same cycle has no effect.
- R5: `lock_retry` is high, in the same cycle, for a lock request with a nonzero count whose target line is unpinned while all other ways of that set are pinned. A refused request changes no state.
- R6: A consume at a line whose count is zero, without `tile_done`, leaves the count at zero. It sets `err_underflow` from the next edge, and the flag stays set until reset.
- R7: `repl_mask` bit w is 1 exactly when way w of set `query_set` has a zero count. Bit w corresponds to way index w, and the mask follows `query_set` without a clock delay.
- R8: A lock request with a count of zero is always accepted and unpins the addressed line.
- R9: When a lock and a consume target the same line in one cycle, the line takes the lock's count and the consume is dropped.
- R10: No set ever has all of its ways pinned, so `repl_mask` is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lock_valid | input | 1 | Lock request strobe |
| lock_set | input | $clog2(SETS) | Set of the line to pin |
| lock_way | input | $clog2(WAYS) | Way of the line to pin |
| lock_count | input | CW | Number of objects the tile needs from the line |
| lock_retry | output | 1 | Request refused to keep one way free; retry later |
| consume_valid | input | 1 | One object consumed from a line |
| consume_set | input | $clog2(SETS) | Set of the consumed line |
| consume_way | input | $clog2(WAYS) | Way of the consumed line |
| tile_done | input | 1 | End of tile; releases all lines |
| query_set | input | $clog2(SETS) | Set whose replaceable mask is presented |
| repl_mask | output | WAYS | Replaceable ways of `query_set` (1 = may be evicted) |
| err_underflow | output | 1 | Sticky flag: a consume reached an unpinned line |

## Verification
A count that is wrong by one leaves a line pinned for one consume too many, or frees it one consume too early. This shows at `repl_mask` on the cycle after the consume that should have freed it, but only while the bench queries that set. The bench compares every way of the queried set on every clock against its own model. A miscounted set occupancy appears as a wrong `lock_retry` in the very cycle of the next request to that set. A missing saturation shows up at a later lock request, which then sees a pinned way that should be free. The long random phase uses four ways per set, so sets fill often and the refusal boundary is crossed many times.

// File: rtl/line_lock_tracker.sv
module line_lock_tracker #(
  parameter int SETS = 16,
  parameter int WAYS = 16,
  parameter int CW   = 6,
  localparam int SW  = $clog2(SETS),
  localparam int WW  = $clog2(WAYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lock_valid,
  input  logic [SW-1:0]   lock_set,
  input  logic [WW-1:0]   lock_way,
  input  logic [CW-1:0]   lock_count,
  output logic            lock_retry,
  input  logic            consume_valid,
  input  logic [SW-1:0]   consume_set,
  input  logic [WW-1:0]   consume_way,
  input  logic            tile_done,
  input  logic [SW-1:0]   query_set,
  output logic [WAYS-1:0] repl_mask,
  output logic            err_underflow
);

  logic [CW-1:0]   cnt  [SETS][WAYS];
  logic [WAYS-1:0] busy [SETS];

  logic [WAYS-1:0] tgt_busy;
  logic            lock_ok;
  logic            cons_zero;

  assign tgt_busy   = busy[lock_set];
  assign lock_retry = lock_valid && (lock_count != '0) && !tgt_busy[lock_way]
                      && ($countones(tgt_busy) >= WAYS - 1);
  assign lock_ok    = lock_valid && !lock_retry;
  assign cons_zero  = consume_valid && !busy[consume_set][consume_way];
  assign repl_mask  = ~busy[query_set];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic hit_lock, hit_cons;
      assign hit_lock     = lock_ok && (lock_set == s) && (lock_way == w);
      assign hit_cons     = consume_valid && (consume_set == s) && (consume_way == w);
      assign busy[s][w]   = |cnt[s][w];

      always_ff @(posedge clk) begin
        if (!rst_n || tile_done)           cnt[s][w] <= '0;
        else if (hit_lock)                 cnt[s][w] <= lock_count;
        else if (hit_cons && busy[s][w])   cnt[s][w] <= cnt[s][w] - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       err_underflow <= 1'b0;
    else if (cons_zero && !tile_done) err_underflow <= 1'b1;
  end

  // R2
  lock_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_valid && !lock_retry && !tile_done
    |=> cnt[$past(lock_set)][$past(lock_way)] == $past(lock_count));

  // R5
  retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_retry |=> cnt[$past(lock_set)][$past(lock_way)] == '0);

  // R4
  tile_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tile_done |=> repl_mask == '1);

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume_valid && !tile_done && cnt[consume_set][consume_way] == '0 |=> err_underflow);

  // R10
  free_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
    repl_mask != '0);

endmodule

// File: tb/line_lock_tracker_test.sv
module line_lock_tracker_test;
  localparam int PERIOD = 10;
  localparam int S = 4;
  localparam int W = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lock_valid = 0, consume_valid = 0, tile_done = 0;
  logic [1:0] lock_set = 0, lock_way = 0, consume_set = 0, consume_way = 0, query_set = 0;
  logic [5:0] lock_count = 0;
  logic lock_retry, err_underflow;
  logic [W-1:0] repl_mask;

  int checks = 0, fails = 0;
  int m [S][W];
  bit merr = 0;
  bit last_retry;

  always #(PERIOD/2) clk = ~clk;

  line_lock_tracker #(.SETS(S), .WAYS(W), .CW(6)) uut (
    .clk(clk), .rst_n(rst_n),
    .lock_valid(lock_valid), .lock_set(lock_set), .lock_way(lock_way),
    .lock_count(lock_count), .lock_retry(lock_retry),
    .consume_valid(consume_valid), .consume_set(consume_set), .consume_way(consume_way),
    .tile_done(tile_done), .query_set(query_set),
    .repl_mask(repl_mask), .err_underflow(err_underflow));

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_mask(int s);
    int r = 0;
    for (int w = 0; w < W; w++) if (m[s][w] == 0) r |= (1 << w);
    return r;
  endfunction

  task automatic step(bit lv, int ls, int lw, int lc, bit cv, int cs, int cw, bit td, int qs);
    int nb = 0;
    bit er;
    @(negedge clk);
    lock_valid = lv; lock_set = ls[1:0]; lock_way = lw[1:0]; lock_count = lc[5:0];
    consume_valid = cv; consume_set = cs[1:0]; consume_way = cw[1:0];
    tile_done = td; query_set = qs[1:0];
    #1;
    for (int w = 0; w < W; w++) if (m[ls][w] != 0) nb++;
    er = lv && lc != 0 && m[ls][lw] == 0 && nb >= W - 1;
    chk("R5 retry", lock_retry, er);
    chk("R7 mask", repl_mask, exp_mask(qs));
    chk("R6 err", err_underflow, merr);
    last_retry = lock_retry;
    @(posedge clk);
    if (td) begin
      for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) m[s][w] = 0;
    end else begin
      if (cv) begin
        if (m[cs][cw] == 0) merr = 1;
        else m[cs][cw]--;
      end
      if (lv && !er) m[ls][lw] = lc;
    end
  endtask

  task automatic look(int qs, int em, string tag);
    @(negedge clk);
    lock_valid = 0; consume_valid = 0; tile_done = 0; query_set = qs[1:0];
    #1;
    chk(tag, repl_mask, em);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < S; s++) for (int w = 0; w < W; w++) m[s][w] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 mask", repl_mask, 'hF);
    chk("R1 retry", lock_retry, 0);
    chk("R1 err", err_underflow, 0);

    // R2 lock pins line
    step(1, 0, 1, 3, 0, 0, 0, 0, 0);
    look(0, 'hD, "R2 pinned");
    // R3 consumes release after count
    step(0, 0, 0, 0, 1, 0, 1, 0, 0);
    step(0, 0, 0, 0, 1, 0, 1, 0, 0);
    look(0, 'hD, "R3 still pinned");
    step(0, 0, 0, 0, 1, 0, 1, 0, 0);
    look(0, 'hF, "R3 released");

    // R5 last free way refused
    step(1, 1, 0, 1, 0, 0, 0, 0, 1);
    step(1, 1, 1, 1, 0, 0, 0, 0, 1);
    step(1, 1, 2, 1, 0, 0, 0, 0, 1);
    step(1, 1, 3, 2, 0, 0, 0, 0, 1);
    chk("R5 refused", last_retry, 1);
    look(1, 'h8, "R5 unchanged");
    step(1, 1, 0, 5, 0, 0, 0, 0, 1);
    chk("R5 relock accepted", last_retry, 0);
    // R8 zero count unpins
    step(1, 1, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 accepted", last_retry, 0);
    look(1, 'h9, "R8 unpinned");
    // R4 tile done wins over lock
    step(1, 1, 0, 4, 0, 0, 0, 1, 1);
    look(1, 'hF, "R4 cleared");

    // R9 lock beats consume on same line
    step(1, 2, 2, 2, 1, 2, 2, 0, 2);
    step(0, 0, 0, 0, 1, 2, 2, 0, 2);
    look(2, 'hB, "R9 lock won");
    step(0, 0, 0, 0, 1, 2, 2, 0, 2);
    look(2, 'hF, "R9 released");

    // R6 underflow
    step(0, 0, 0, 0, 1, 3, 0, 0, 3);
    look(3, 'hF, "R6 saturated");
    chk("R6 err set", err_underflow, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 3);
    chk("R6 err sticky", err_underflow, 1);

    // random phase, model compared every cycle (R7 R5 R6 R10)
    for (int i = 0; i < 4000; i++) begin
      bit lv = ($urandom % 3) != 0;
      bit cv = ($urandom % 2) != 0;
      bit td = ($urandom % 97) == 0;
      int lc = ($urandom % 4 == 0) ? 0 : ($urandom % 5) + 1;
      step(lv, $urandom % S, $urandom % W, lc, cv, $urandom % S, $urandom % W, td, $urandom % S);
      if (repl_mask == 0) chk("R10 free way", repl_mask, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule